// File: doc/BRIEF.md
# Slave FIFO Write Master

This block moves 32-bit words from a local 64-entry buffer onto an external synchronous slave-FIFO port. A data producer fills the local buffer through a push/full interface at any rate, from every clock down to one word per 256 clocks. The master drives the port's FIFO address, data bus and active-low write strobe. It watches two active-low status inputs from the port: a ready flag, which drops when the downstream buffer can take no more, and a watermark flag, which drops when the downstream buffer is nearly full.

While the watermark flag is high, the master writes whenever the local buffer holds a word and the ready flag is high. Once the watermark flag is sampled low, the master completes the current group of eight words. A wrapping 3-bit counter tracks the position inside the group. The master still writes only on cycles where it has data, so a slow producer stretches the group over many clocks and no filler word is ever sent. After the eighth word the master parks for a fixed hold-off that covers the ready flag's latency. It leaves the parked state only when the ready flag reads high again, and at that point it clears the group counter.

Top module: `sfifo_wr_master`

## Requirements
- R1: Every word accepted on the producer interface appears exactly once on `port_data`, in push order, on a cycle where `port_wr_n` is low. No word is lost and none is duplicated.
- R2: `port_addr` is always 2'b00, the FPGA-to-host FIFO address.
- R3: `port_wr_n` goes low only for a word taken from the local buffer. When the buffer is empty, no write takes place and no filler word is sent, whatever the producer rate.
- R4: After the watermark flag is sampled low, writes continue until the write that takes the 3-bit group counter through the value 7. The downstream buffer therefore receives a whole number of 8-word groups.
- R5: `prod_full` is high exactly when 64 words are stored. A push while `prod_full` is high is ignored: the word never appears on the port.
- R6: After the last write of a group, `port_wr_n` stays high for at least the hold-off (8 clocks by default) and until the ready flag is sampled high. No write lands in the window where the ready flag has not yet fallen.
- R7: On leaving the parked state, the group counter restarts at 0, so the next group is again eight words.
- R8: While reset is asserted, `port_wr_n` is high, `prod_full` is low and `port_addr` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock (100 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| prod_push | input | 1 | Producer write request |
| prod_data | input | 32 | Producer data word |
| prod_full | output | 1 | Local buffer holds 64 words |
| port_rdy | input | 1 | Downstream ready flag; low means no space |
| port_wm_n | input | 1 | Downstream watermark flag; low means nearly full |
| port_addr | output | 2 | Slave FIFO address, fixed at 0 |
| port_data | output | 32 | Data bus toward the slave FIFO |
| port_wr_n | output | 1 | Active-low write strobe |

## Verification
The hardest case to reach is a watermark that falls while the local buffer is starved, so that the rest of the group arrives one word at a time, hundreds of clocks apart. The bench runs the same 64-word stream with producer gaps of 0, 2, 4 and 255 clocks. Its port model raises the watermark and ready flags after a few clocks of latency, and it flags any write past the downstream capacity. A second hard case is a full local buffer with a stalled downstream port. To reach it, the model withholds its drain until 80 words have been accepted, then offers one marker word that must never reach the bus.

// File: rtl/sfwm_pkg.sv
package sfwm_pkg;

   // Sequencer states of the write master
   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,   // free streaming, watermark high
      ST_DRAIN = 2'd1,   // watermark seen, finishing the group
      ST_PARK  = 2'd2    // group done, waiting for the ready flag
   } wr_state_e;

endpackage

// File: rtl/sfwm_buffer.sv
module sfwm_buffer #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] din,
   output logic              full,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic              empty,
   output logic [$clog2(DEPTH):0] level
);
   localparam int unsigned AW = $clog2(DEPTH);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr;
   logic [AW-1:0]     rd_ptr;
   logic [AW:0]       lvl_q;
   logic              push_ok;
   logic              pop_ok;

   assign full    = (lvl_q == (AW+1)'(DEPTH));
   assign empty   = (lvl_q == '0);
   assign push_ok = push & ~full;
   assign pop_ok  = pop & ~empty;
   assign head    = mem[rd_ptr];
   assign level   = lvl_q;

   always_ff @(posedge clk) begin
      if (push_ok) begin
         mem[wr_ptr] <= din;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         lvl_q  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   lvl_q <= lvl_q + 1'b1;
            2'b01:   lvl_q <= lvl_q - 1'b1;
            default: lvl_q <= lvl_q;
         endcase
      end
   end

endmodule

// File: rtl/sfwm_group_ctr.sv
module sfwm_group_ctr #(
   parameter int unsigned GROUP_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               inc,
   input  logic               clr,
   output logic [GROUP_W-1:0] cnt,
   output logic               last
);
   logic [GROUP_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (inc) begin
         cnt_q <= cnt_q + 1'b1;   // wraps after the final slot
      end
   end

   assign cnt  = cnt_q;
   assign last = &cnt_q;

endmodule

// File: rtl/sfwm_seq.sv
module sfwm_seq
   import sfwm_pkg::*;
#(
   parameter int unsigned HOLD = 8
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      empty,
   input  logic      rdy,
   input  logic      wm_n,
   input  logic      last,
   output logic      fire,
   output logic      clr,
   output wr_state_e state
);
   localparam int unsigned HW = $clog2(HOLD + 1);

   wr_state_e st_q;
   wr_state_e st_d;
   logic [HW-1:0] hold_q;

   always_comb begin
      fire = 1'b0;
      clr  = 1'b0;
      st_d = st_q;
      unique case (st_q)
         ST_RUN: begin
            if (!wm_n) begin
               fire = ~empty;
               st_d = (fire && last) ? ST_PARK : ST_DRAIN;
            end else begin
               fire = ~empty & rdy;
            end
         end
         ST_DRAIN: begin
            fire = ~empty;
            if (fire && last) st_d = ST_PARK;
         end
         ST_PARK: begin
            if (hold_q == '0 && rdy) begin
               st_d = ST_RUN;
               clr  = 1'b1;
            end
         end
         default: st_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_RUN;
         hold_q <= '0;
      end else begin
         st_q <= st_d;
         if (st_d == ST_PARK && st_q != ST_PARK) begin
            hold_q <= HW'(HOLD);
         end else if (st_q == ST_PARK && hold_q != '0) begin
            hold_q <= hold_q - 1'b1;
         end
      end
   end

   assign state = st_q;

endmodule

// File: rtl/sfifo_wr_master.sv
module sfifo_wr_master
   import sfwm_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned DEPTH     = 64,
   parameter int unsigned GROUP_W   = 3,
   parameter int unsigned HOLD      = 8,
   parameter int unsigned ADDR_W    = 2,
   parameter int unsigned FIFO_ADDR = 0,
   parameter bit          OUT_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prod_push,
   input  logic [DATA_W-1:0] prod_data,
   output logic              prod_full,
   input  logic              port_rdy,
   input  logic              port_wm_n,
   output logic [ADDR_W-1:0] port_addr,
   output logic [DATA_W-1:0] port_data,
   output logic              port_wr_n
);
   localparam int unsigned LVL_W = $clog2(DEPTH) + 1;

   // Elaboration-time parameter checks
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (GROUP_W < 1) begin : g_bad_group
      $error("GROUP_W must be at least 1");
   end
   if (HOLD < 1) begin : g_bad_hold
      $error("HOLD must be at least 1");
   end
   if (FIFO_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("FIFO_ADDR does not fit in ADDR_W bits");
   end

   logic              buf_empty;
   logic [DATA_W-1:0] buf_head;
   logic [LVL_W-1:0]  buf_level;
   logic              seq_fire;
   logic              seq_clr;
   wr_state_e         seq_st;
   logic [GROUP_W-1:0] grp_cnt;
   logic              grp_last;

   sfwm_buffer #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (prod_push),
      .din   (prod_data),
      .full  (prod_full),
      .pop   (seq_fire),
      .head  (buf_head),
      .empty (buf_empty),
      .level (buf_level)
   );

   sfwm_group_ctr #(.GROUP_W(GROUP_W)) u_grp (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (seq_fire),
      .clr   (seq_clr),
      .cnt   (grp_cnt),
      .last  (grp_last)
   );

   sfwm_seq #(.HOLD(HOLD)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .empty (buf_empty),
      .rdy   (port_rdy),
      .wm_n  (port_wm_n),
      .last  (grp_last),
      .fire  (seq_fire),
      .clr   (seq_clr),
      .state (seq_st)
   );

   assign port_addr = ADDR_W'(FIFO_ADDR);

   if (OUT_REG) begin : g_out_reg
      logic              wr_q;
      logic [DATA_W-1:0] data_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wr_q   <= 1'b1;
            data_q <= '0;
         end else begin
            wr_q <= ~seq_fire;
            if (seq_fire) data_q <= buf_head;
         end
      end
      assign port_wr_n = wr_q;
      assign port_data = data_q;
   end else begin : g_out_comb
      assign port_wr_n = ~seq_fire;
      assign port_data = buf_head;
   end

endmodule

// File: rtl/sfwm_checker.sv
module sfwm_checker
   import sfwm_pkg::*;
#(
   parameter int unsigned DEPTH   = 64,
   parameter int unsigned GROUP_W = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  wr_state_e               st,
   input  logic                    fire,
   input  logic                    empty,
   input  logic [GROUP_W-1:0]      cnt,
   input  logic [$clog2(DEPTH):0]  level,
   input  logic                    full,
   input  logic                    port_wr_n
);

   // R3: a word is only taken when the local buffer holds one
   p_no_pop_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> !empty);

   // R4: the write through the last group slot while draining ends in park
   p_group_park_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DRAIN && fire && (&cnt)) |=> (st == ST_PARK));

   // R5: occupancy never exceeds capacity
   p_buf_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      level <= ($clog2(DEPTH)+1)'(DEPTH));

   // R5: a full buffer without a pop keeps its level
   p_full_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !fire) |=> (level == $past(level)));

   // R6: the strobe stays high while parked
   p_park_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PARK && $past(st) == ST_PARK) |-> port_wr_n);

   // R7: counter restarts when streaming resumes
   p_resume_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st) == ST_PARK && st == ST_RUN) |-> (cnt == '0));

endmodule

bind sfifo_wr_master sfwm_checker #(.DEPTH(DEPTH), .GROUP_W(GROUP_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .st        (seq_st),
   .fire      (seq_fire),
   .empty     (buf_empty),
   .cnt       (grp_cnt),
   .level     (buf_level),
   .full      (prod_full),
   .port_wr_n (port_wr_n)
);

// File: tb/sfifo_wr_master_tb.sv
module sfifo_wr_master_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        prod_push;
   logic [31:0] prod_data;
   logic        prod_full;
   logic        port_rdy;
   logic        port_wm_n;
   logic [1:0]  port_addr;
   logic [31:0] port_data;
   logic        port_wr_n;

   always #5 clk = ~clk;

   sfifo_wr_master u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .prod_push (prod_push),
      .prod_data (prod_data),
      .prod_full (prod_full),
      .port_rdy  (port_rdy),
      .port_wm_n (port_wm_n),
      .port_addr (port_addr),
      .port_data (port_data),
      .port_wr_n (port_wr_n)
   );

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   logic [31:0] expq [$];
   logic [31:0] exp_w;
   int   fill, dcnt, groups, delivered;
   bit   drain_en;
   bit [3:0] rdy_pipe;
   bit [1:0] wm_pipe;

   localparam int CAP     = 16;  // downstream buffer: two groups
   localparam int WM_LVL  = 8;
   localparam int DRAIN_T = 12;

   assign port_rdy  = rdy_pipe[3];
   assign port_wm_n = wm_pipe[1];

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(posedge clk) cyc++;

   // Behavioural downstream port model, evaluated away from the active edge
   always @(negedge clk) begin
      if (!rst_n) begin
         fill = 0; dcnt = 0; groups = 0; delivered = 0;
         rdy_pipe = 4'hF; wm_pipe = 2'b11;
      end else begin
         if (port_wr_n == 1'b0) begin
            chk(port_addr == 2'b00, "R2 address", port_addr, 0);
            chk(fill < CAP, "R4 R6 write beyond downstream space", fill, CAP - 1);
            if (expq.size() == 0) begin
               chk(1'b0, "R3 write with no pushed word", port_data, 0);
            end else begin
               exp_w = expq.pop_front();
               chk(port_data == exp_w, "R1 data order", port_data, exp_w);
            end
            fill++;
            delivered++;
         end
         if (fill >= CAP && drain_en) begin
            dcnt++;
            if (dcnt >= DRAIN_T) begin
               fill = 0; dcnt = 0; groups++;
            end
         end
         rdy_pipe = {rdy_pipe[2:0], fill < CAP};
         wm_pipe  = {wm_pipe[0], fill < WM_LVL};
      end
   end

   task automatic do_reset();
      rst_n = 1'b0; prod_push = 1'b0; prod_data = '0; drain_en = 1'b1;
      expq.delete();
      repeat (3) @(negedge clk);
      chk(port_wr_n == 1'b1, "R8 reset strobe", port_wr_n, 1);
      chk(prod_full == 1'b0, "R8 reset full", prod_full, 0);
      chk(port_addr == 2'b00, "R8 reset address", port_addr, 0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic push_words(input int n, input int div, input logic [31:0] base);
      for (int i = 0; i < n; i++) begin
         while (prod_full) @(negedge clk);
         prod_push = 1'b1;
         prod_data = base + 32'(i);
         expq.push_back(base + 32'(i));
         @(negedge clk);
         prod_push = 1'b0;
         repeat (div) @(negedge clk);
      end
   endtask

   task automatic wait_groups(input int n);
      int t = 0;
      while (groups < n && t < 40000) begin
         @(negedge clk);
         t++;
      end
   endtask

   task automatic stream_run(input int div);
      do_reset();
      push_words(64, div, 32'h1000_0000 * 32'(div + 1));
      wait_groups(4);
      chk(delivered == 64, "R1 words delivered", delivered, 64);
      chk(expq.size() == 0, "R1 words pending", expq.size(), 0);
      chk(groups == 4, "R4 R7 whole groups", groups, 4);
      repeat (20) @(negedge clk);
      chk(port_wr_n == 1'b1, "R3 idle with empty buffer", port_wr_n, 1);
      chk(delivered == 64, "R3 no filler word", delivered, 64);
   endtask

   initial begin : watchdog
      wait (cyc >= 190000);
      chk(1'b0, "watchdog expired", cyc, 190000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      rst_n = 1'b0; prod_push = 1'b0; prod_data = '0; drain_en = 1'b1;
      @(negedge clk);
      stream_run(0);
      stream_run(2);
      stream_run(4);
      stream_run(255);   // R3 slow producer, group completes over many clocks

      // R5: local buffer fills while downstream is held full
      do_reset();
      drain_en = 1'b0;
      push_words(80, 0, 32'hA000_0000);
      repeat (5) @(negedge clk);
      chk(prod_full == 1'b1, "R5 full flag", prod_full, 1);
      chk(delivered == CAP, "R6 parked at downstream capacity", delivered, CAP);
      prod_push = 1'b1;
      prod_data = 32'hDEAD_BEEF;   // must be ignored
      @(negedge clk);
      prod_push = 1'b0;
      chk(prod_full == 1'b1, "R5 full after ignored push", prod_full, 1);
      drain_en = 1'b1;
      wait_groups(5);
      repeat (20) @(negedge clk);
      chk(delivered == 80, "R5 ignored push not delivered", delivered, 80);
      chk(expq.size() == 0, "R5 all stored words delivered", expq.size(), 0);
      chk(groups == 5, "R7 groups after resume", groups, 5);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule